// File: doc/BRIEF.md
# Reset Cause and Break-Exit Status Register

This block is a small status unit that sits beside a CPU's system-integration logic. It keeps a record of what caused the most recent reset. Seven sources are recorded: power-on, the external reset pin, the watchdog, an illegal opcode, an illegal address, a forced module reset and a low-voltage detect. The reset sequencer, the watchdog, the voltage detector and the break logic are outside the block. Each of them reports to it with a one-cycle event pulse.

The block also keeps a flag that says a low-power stop or wait state was left because of a debug break interrupt. A break service routine reads this flag to decide whether to return into the low-power state. Once it has acted, it writes a zero to the flag. The reset-cause byte clears itself when it is read. A power-on event always masks every other cause.

The two status bytes are reached over a simple register bus with read strobe, write strobe, address and 8-bit data. Read data is combinational and appears in the same cycle as the read strobe.

Top module: `reset_cause_status`

## Requirements
- R1: The cause byte reports, from bit 7 down to bit 1, the power-on, pin, watchdog, illegal-opcode, illegal-address, module-reset and low-voltage flags. Bit 0 always reads 0.
- R2: A power-on pulse leaves the cause byte at 0x80, whatever other sources pulse in the same cycle.
- R3: A reset pulse without power-on replaces the previous flags with the flags of the sources pulsing in that cycle. All simultaneous sources are set.
- R4: A read of the cause byte returns the value held before the read. All flags are cleared at the clock edge that ends the read cycle.
- R5: When a reset pulse and a cause-byte read fall in the same cycle, the read returns the old value and the new reset flags are kept.
- R6: Writes to the cause-byte address leave its flags unchanged.
- R7: A break-exit pulse sets the break flag, which reads at bit 1 of the break byte. All other bits of the break byte read 0, and reading the byte does not clear the flag.
- R8: Writing a byte with bit 1 equal to 0 to the break address clears the flag, and writing one with bit 1 equal to 1 leaves it unchanged. A break-exit pulse in the same cycle as a clearing write wins.
- R9: Any reset source pulse clears the break flag, even when a break-exit pulse occurs in the same cycle.
- R10: The cause byte is at address 1 and the break byte at address 0. Reads of any other address, and all cycles without a read strobe, return 0. A read of another address does not clear the cause byte.
- R11: While the synchronous active-low reset is held low at a clock edge, both status bytes are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_evt | input | 1 | Power-on reset event pulse |
| pin_evt | input | 1 | External reset pin event pulse |
| wdog_evt | input | 1 | Watchdog reset event pulse |
| illop_evt | input | 1 | Illegal opcode reset event pulse |
| illaddr_evt | input | 1 | Illegal address reset event pulse |
| modrst_evt | input | 1 | Forced module reset event pulse |
| lowv_evt | input | 1 | Low-voltage reset event pulse |
| brk_exit | input | 1 | Low-power state left by a break interrupt |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, zero when no mapped read is in progress |

## Verification
The bench builds the block with its default parameters: a 4-bit address, the cause byte at address 1 and the break flag at bit 1 of address 0. With seven sources, all 128 combinations of simultaneous reset pulses can be driven, and each is read back twice to show the value and then the clear. With 16 addresses, every unmapped location can be read for a zero and checked for no side effect. The narrow configuration also makes every same-cycle collision cheap to reach. These collisions are reset against read, break pulse against clearing write, and reset against break pulse.

// File: rtl/rcs_pkg.sv
// Shared constants for the reset cause / break-exit status unit.
// Assumes an 8-bit register bus and seven reset sources whose order in
// the cause byte is fixed by software that decodes it.
package rcs_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NUM_SRC  = 7;
    // Source index inside the source vector; cause byte bit = index + 1.
    localparam int unsigned IDX_LOWV    = 0;
    localparam int unsigned IDX_MODRST  = 1;
    localparam int unsigned IDX_ILLADDR = 2;
    localparam int unsigned IDX_ILLOP   = 3;
    localparam int unsigned IDX_WDOG    = 4;
    localparam int unsigned IDX_PIN     = 5;
    localparam int unsigned IDX_POR     = 6;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [DATA_W-1:0]  byte_t;
endpackage

// File: rtl/rcs_cause_flags.sv
// Reset-cause flag store.
// A power-on event masks all other sources. Any other event replaces the
// old flags with the set of sources pulsing now. A read-clear request
// empties the store unless an event arrives in the same cycle.
// Assumes event pulses are already synchronous to clk.
module rcs_cause_flags
    import rcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t src_evt,
    input  logic     rd_clear,
    output src_vec_t flags_q
);
    logic     any_evt;
    src_vec_t evt_next;

    // Any source active this cycle
    assign any_evt = |src_evt;

    // Per-source next value: power-on wins over every other source
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i == IDX_POR) begin : g_por
            assign evt_next[i] = src_evt[i];
        end else begin : g_other
            assign evt_next[i] = src_evt[i] & ~src_evt[IDX_POR];
        end
    end

    // Flag register: event has priority over read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (any_evt) begin
            flags_q <= evt_next;
        end else if (rd_clear) begin
            flags_q <= '0;
        end
    end
endmodule

// File: rtl/rcs_break_flag.sv
// Break-exit flag.
// Set by a break-exit pulse and cleared by a bus write whose flag bit is
// zero; a reset event clears it above all else.
// Assumes the write select is already decoded for the break address.
module rcs_break_flag
    import rcs_pkg::*;
#(
    parameter int unsigned BRK_BIT = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  any_reset,
    input  logic  brk_pulse,
    input  logic  wr_sel,
    input  byte_t wdata,
    output logic  flag_q
);
    logic wr_clear;
    logic unused_wbits;

    // Only the flag bit of the write data matters
    assign wr_clear     = wr_sel & ~wdata[BRK_BIT];
    assign unused_wbits = ^wdata;

    // Flag register: reset event > break pulse > clearing write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (any_reset) begin
            flag_q <= 1'b0;
        end else if (brk_pulse) begin
            flag_q <= 1'b1;
        end else if (wr_clear) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rcs_bus_decode.sv
// Register bus decoder and read multiplexer.
// Produces the cause read-clear strobe and the break write select, and
// drives read data combinationally; unmapped or idle cycles read zero.
// Assumes the two addresses differ.
module rcs_bus_decode
    import rcs_pkg::*;
#(
    parameter int unsigned          ADDR_W     = 4,
    parameter logic [ADDR_W-1:0]    CAUSE_ADDR = 1,
    parameter logic [ADDR_W-1:0]    BRK_ADDR   = 0
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             cause_byte,
    input  byte_t             brk_byte,
    output byte_t             rdata,
    output logic              cause_rd,
    output logic              brk_wr
);
    logic hit_cause;
    logic hit_brk;

    // Address match lines
    assign hit_cause = (addr == CAUSE_ADDR);
    assign hit_brk   = (addr == BRK_ADDR);

    // Side-effect strobes
    assign cause_rd = rd_en & hit_cause;
    assign brk_wr   = wr_en & hit_brk;

    // Read data selection
    always_comb begin
        rdata = '0;
        if (rd_en && hit_cause) begin
            rdata = cause_byte;
        end else if (rd_en && hit_brk) begin
            rdata = brk_byte;
        end
    end
endmodule

// File: rtl/reset_cause_status.sv
// Reset cause and break-exit status unit (top).
// Gathers the seven reset event pulses into the source vector, keeps the
// cause flags and the break flag, and serves both as bytes on the bus.
// Assumes all inputs are synchronous to clk and each event is one cycle.
module reset_cause_status
    import rcs_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 1,
    parameter logic [ADDR_W-1:0] BRK_ADDR   = 0,
    parameter int unsigned       BRK_BIT    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_evt,
    input  logic              pin_evt,
    input  logic              wdog_evt,
    input  logic              illop_evt,
    input  logic              illaddr_evt,
    input  logic              modrst_evt,
    input  logic              lowv_evt,
    input  logic              brk_exit,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    src_vec_t src_evt;
    src_vec_t flags_q;
    byte_t    cause_byte;
    byte_t    brk_byte;
    logic     brk_flag;
    logic     cause_rd;
    logic     brk_wr;

    // Source vector in cause-byte order
    always_comb begin
        src_evt              = '0;
        src_evt[IDX_POR]     = por_evt;
        src_evt[IDX_PIN]     = pin_evt;
        src_evt[IDX_WDOG]    = wdog_evt;
        src_evt[IDX_ILLOP]   = illop_evt;
        src_evt[IDX_ILLADDR] = illaddr_evt;
        src_evt[IDX_MODRST]  = modrst_evt;
        src_evt[IDX_LOWV]    = lowv_evt;
    end

    // Cause byte: flags above an always-zero bit 0
    assign cause_byte = {flags_q, 1'b0};

    // Break byte: only the flag position is populated
    for (genvar b = 0; b < DATA_W; b++) begin : g_brk_byte
        if (b == BRK_BIT) begin : g_flag
            assign brk_byte[b] = brk_flag;
        end else begin : g_zero
            assign brk_byte[b] = 1'b0;
        end
    end

    rcs_cause_flags u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .rd_clear (cause_rd),
        .flags_q  (flags_q)
    );

    rcs_break_flag #(.BRK_BIT(BRK_BIT)) u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_reset (|src_evt),
        .brk_pulse (brk_exit),
        .wr_sel    (brk_wr),
        .wdata     (wdata),
        .flag_q    (brk_flag)
    );

    rcs_bus_decode #(
        .ADDR_W     (ADDR_W),
        .CAUSE_ADDR (CAUSE_ADDR),
        .BRK_ADDR   (BRK_ADDR)
    ) u_dec (
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .cause_byte (cause_byte),
        .brk_byte   (brk_byte),
        .rdata      (rdata),
        .cause_rd   (cause_rd),
        .brk_wr     (brk_wr)
    );
endmodule

// File: rtl/rcs_checker.sv
// Property checker for reset_cause_status, attached by bind.
// Observes the ports plus the stored cause byte and break flag.
module rcs_checker
    import rcs_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 1,
    parameter logic [ADDR_W-1:0] BRK_ADDR   = 0,
    parameter int unsigned       BRK_BIT    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input src_vec_t          src_evt,
    input logic              brk_exit,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input byte_t             cause_byte,
    input logic              brk_flag
);
    logic cause_read;
    logic no_evt;
    assign cause_read = rd_en && (addr == CAUSE_ADDR);
    assign no_evt     = (src_evt == '0);

    a_r2_por_masks: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt[IDX_POR] |=> cause_byte == 8'h80);

    a_r3_replace_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_evt && !src_evt[IDX_POR]) |=> cause_byte == {$past(src_evt), 1'b0});

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_read && no_evt) |=> cause_byte == 8'h00);

    a_r4_read_old_value: assert property (@(posedge clk) disable iff (!rst_n)
        cause_read |-> rdata == cause_byte);

    a_r6_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CAUSE_ADDR && no_evt && !cause_read) |=> $stable(cause_byte));

    a_r7_break_set: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_exit && no_evt) |=> brk_flag);

    a_r8_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == BRK_ADDR && wdata[BRK_BIT] && !brk_exit && no_evt)
        |=> $stable(brk_flag));

    a_r8_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == BRK_ADDR && !wdata[BRK_BIT] && !brk_exit && no_evt)
        |=> !brk_flag);

    a_r9_reset_clears_break: assert property (@(posedge clk) disable iff (!rst_n)
        !no_evt |=> !brk_flag);

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || (addr != CAUSE_ADDR && addr != BRK_ADDR)) |-> rdata == 8'h00);

    a_r7_break_byte_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == BRK_ADDR) |-> $countones(rdata) == (brk_flag ? 1 : 0));
endmodule

bind reset_cause_status rcs_checker #(
    .ADDR_W     (ADDR_W),
    .CAUSE_ADDR (CAUSE_ADDR),
    .BRK_ADDR   (BRK_ADDR),
    .BRK_BIT    (BRK_BIT)
) u_rcs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt    (src_evt),
    .brk_exit   (brk_exit),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .cause_byte (cause_byte),
    .brk_flag   (brk_flag)
);

// File: tb/reset_cause_status_test.sv
// Self-checking bench: sweeps all source combinations and all addresses.
module reset_cause_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src = '0;     // bit6 power-on ... bit0 low-voltage
    logic       brk = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    int         n_chk = 0;
    int         n_bad = 0;

    localparam logic [3:0] A_CAUSE = 4'd1;
    localparam logic [3:0] A_BRK   = 4'd0;

    always #5 clk = ~clk;

    reset_cause_status uut (
        .clk(clk), .rst_n(rst_n),
        .por_evt(src[6]), .pin_evt(src[5]), .wdog_evt(src[4]),
        .illop_evt(src[3]), .illaddr_evt(src[2]), .modrst_evt(src[1]),
        .lowv_evt(src[0]), .brk_exit(brk),
        .rd_en(rd), .wr_en(wr), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] exp_cause(input logic [6:0] p);
        if (p[6]) return 8'h80;
        return {p, 1'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [6:0] p, input logic b);
        @(negedge clk); src = p; brk = b;
        @(negedge clk); src = '0; brk = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 check(req, rdata, exp);
        @(negedge clk); rd = 1'b0; addr = '0;
    endtask

    task automatic wr_do(input logic [3:0] a, input logic [7:0] d, input logic b);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d; brk = b;
        @(negedge clk); wr = 1'b0; addr = '0; wdata = '0; brk = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(A_CAUSE, 8'h00, "R11 cause after reset");
        rd_chk(A_BRK,   8'h00, "R11 break after reset");
        // R10: no strobe reads zero even with data present
        pulse(7'h20, 1'b0);
        @(negedge clk); addr = A_CAUSE; #1 check("R10 idle bus", rdata, 8'h00);
        rd_chk(A_CAUSE, 8'h40, "R1 pin flag at bit 6");

        // R1 R2 R3 R4: every source combination, then read-clear
        for (int p = 1; p < 128; p++) begin
            pulse(7'(p), 1'b0);
            rd_chk(A_CAUSE, exp_cause(7'(p)), "R2/R3 cause value");
            rd_chk(A_CAUSE, 8'h00, "R4 cleared after read");
        end

        // R3: a later event replaces earlier flags
        pulse(7'h10, 1'b0);
        pulse(7'h01, 1'b0);
        rd_chk(A_CAUSE, 8'h02, "R3 replace previous");
        pulse(7'h0C, 1'b0);
        pulse(7'h40, 1'b0);
        rd_chk(A_CAUSE, 8'h80, "R2 power-on after others");

        // R5: reset event in the read cycle
        pulse(7'h20, 1'b0);
        @(negedge clk); rd = 1'b1; addr = A_CAUSE; src = 7'h10;
        #1 check("R5 read returns old value", rdata, 8'h40);
        @(negedge clk); rd = 1'b0; src = '0;
        rd_chk(A_CAUSE, 8'h20, "R5 new flag kept");

        // R6: writes to the cause address ignored
        pulse(7'h08, 1'b0);
        wr_do(A_CAUSE, 8'hFF, 1'b0);
        wr_do(A_CAUSE, 8'h00, 1'b0);
        rd_chk(A_CAUSE, 8'h10, "R6 writes ignored");

        // R7: break flag set, read does not clear
        pulse(7'h00, 1'b1);
        rd_chk(A_BRK, 8'h02, "R7 break set");
        rd_chk(A_BRK, 8'h02, "R7 read keeps break");
        // R8: write one keeps, write zero clears, pulse beats clear
        wr_do(A_BRK, 8'hFF, 1'b0);
        rd_chk(A_BRK, 8'h02, "R8 write one keeps");
        wr_do(A_BRK, 8'hFD, 1'b0);
        rd_chk(A_BRK, 8'h00, "R8 write zero clears");
        wr_do(A_BRK, 8'h00, 1'b1);
        rd_chk(A_BRK, 8'h02, "R8 pulse beats clearing write");

        // R9: reset events clear break, also against a simultaneous pulse
        pulse(7'h01, 1'b0);
        rd_chk(A_BRK, 8'h00, "R9 reset clears break");
        pulse(7'h00, 1'b1);
        pulse(7'h40, 1'b1);
        rd_chk(A_BRK, 8'h00, "R9 reset beats break pulse");

        // R10: unmapped addresses read zero and do not clear
        pulse(7'h00, 1'b1);
        pulse(7'h04, 1'b0);
        pulse(7'h00, 1'b1);
        for (int a = 2; a < 16; a++) begin
            rd_chk(4'(a), 8'h00, "R10 unmapped reads zero");
        end
        rd_chk(A_CAUSE, 8'h08, "R10 cause kept after unmapped reads");
        rd_chk(A_BRK,   8'h02, "R10 break kept after unmapped reads");

        // R11: synchronous reset clears both bytes
        pulse(7'h02, 1'b0);
        pulse(7'h00, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk(A_CAUSE, 8'h00, "R11 cause cleared by rst_n");
        rd_chk(A_BRK,   8'h00, "R11 break cleared by rst_n");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule